// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block learns, once, the correction needed to cancel the combined offset of the programmable-gain stage and the converter input. It then holds that correction for the rest of operation. The learning window opens when the register-controlled reset-mode bit is released. While the window is open, the block compares each converter sample with the black-level clamp target. It nudges a signed correction one LSB per clock toward the point where the sample equals the target. The window closes after a fixed number of clocks, 40000 by default. The correction is then frozen and a one-cycle completion pulse is given.

The code sent to the offset DAC is the frozen (or still-learning) correction plus the programmed clamp level, limited to the DAC's range. The clamp level can be reprogrammed at any time, and that change reaches the DAC code in the same cycle. Setting the reset-mode bit again wipes the correction and re-arms the sequencer, so the next release runs a complete new window.

Top module: `osc_cal_seq`

## Requirements
- R1: While hardware reset `rst_n` is low, and afterwards for as long as `rst_mode` stays high, the block is armed and idle: `cal_busy` = 0, `cal_done` = 0, correction = 0, so `dac_code` equals the effective clamp.
- R2: When armed, the first clock edge that samples `rst_mode` low starts calibration. `cal_busy` is then high for exactly CAL_CYCLES (default 40000) consecutive cycles.
- R3: `cal_done` is high for exactly one cycle. That cycle is the first cycle after `cal_busy` falls at the end of a complete window, and `cal_done` is never high together with `cal_busy`.
- R4: At each clock edge that samples the block calibrating with `rst_mode` low, the correction changes by one step. It goes +1 when `adc_sample` is below the effective clamp, -1 when above, and 0 when equal (unsigned 10-bit compare).
- R5: The correction is a signed 8-bit value that stops at +127 and at -128 instead of wrapping.
- R6: `dac_code` = correction + effective clamp, limited to 0..1023. It is combinational in `clamp_code`, so a clamp change is visible in the same cycle.
- R7: The effective clamp is `clamp_code` limited to 14..76. Codes below 14 act as 14 and codes above 76 act as 76, both as DAC offset and as calibration target.
- R8: After `cal_done` and while `rst_mode` stays low, the correction is frozen: `adc_sample` has no effect on `dac_code`, and no new window starts.
- R9: `rst_mode` high at any time clears the correction to 0 at the next edge. If a window is running, it ends with `cal_busy` falling and no `cal_done`. The block is then re-armed, and the next release runs a full new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rst_mode | input | 1 | Register reset-mode bit; high holds the sequencer armed and clears the correction |
| adc_sample | input | 10 | Converter output, used only while calibrating |
| clamp_code | input | 7 | Programmed black-level clamp level |
| dac_code | output | 10 | Offset DAC code: correction plus effective clamp, limited |
| cal_busy | output | 1 | High during the calibration window |
| cal_done | output | 1 | One-cycle pulse at the end of a complete window |

## Verification
The learning loop is closed through a plant model in the bench. The model feeds back the DAC code shifted by a chosen analog offset, so each window has a known answer. A small negative offset must converge to an exact interior correction. A large positive offset drives the correction to its negative stop and the DAC code to zero. A large negative offset drives the correction to its positive stop. Together these separate correct stepping from wrong direction, wrapping and missing limits. A table of clamp codes and plant disturbances applied after completion covers the remaining parts. It separates clamp limiting at both bounds, from in-range pass-through, from any leak of the converter sample into a frozen correction. A mid-window abort tells a proper clear-and-re-arm apart from a spurious completion pulse.

// File: rtl/osc_pkg.sv
`timescale 1ns/1ps
package osc_pkg;
  // Sequencer phases
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2
  } cal_state_e;

  // Direction of one correction step
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/osc_cal_timer.sv
`timescale 1ns/1ps
module osc_cal_timer
  import osc_pkg::*;
#(
  parameter int CAL_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_mode,
  output logic cal_busy,
  output logic cal_done,
  output logic cal_start,
  output logic cal_abort,
  output logic cal_last
);
  localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CAL_CYCLES - 1);

  cal_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q;

  // Named events for the checker
  assign cal_start = (state_q == ST_ARMED) && !rst_mode;
  assign cal_abort = (state_q != ST_ARMED) && rst_mode;
  assign cal_last  = (state_q == ST_RUN) && !rst_mode && (cnt_q == LAST_CNT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_ARMED: begin
        if (!rst_mode) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (rst_mode)            state_d = ST_ARMED;
        else if (cnt_q == LAST_CNT) state_d = ST_HOLD;
        else                     cnt_d   = cnt_q + 1'b1;
      end
      ST_HOLD: begin
        if (rst_mode) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= cal_last;
    end
  end

  assign cal_busy = (state_q == ST_RUN);
  assign cal_done = done_q;
endmodule

// File: rtl/osc_corr_accum.sv
`timescale 1ns/1ps
module osc_corr_accum
  import osc_pkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int CORR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     enable,
  input  logic [ADC_W-1:0]         adc_sample,
  input  logic [ADC_W-1:0]         target,
  output logic signed [CORR_W-1:0] corr_q
);
  localparam logic signed [CORR_W-1:0] CORR_MAX = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic signed [CORR_W-1:0] CORR_MIN = {1'b1, {(CORR_W-1){1'b0}}};
  localparam logic signed [CORR_W-1:0] ONE      = CORR_W'(1);

  function automatic step_e pick_step(input logic [ADC_W-1:0] s,
                                      input logic [ADC_W-1:0] t);
    if (s < t)      return STEP_UP;
    else if (s > t) return STEP_DOWN;
    else            return STEP_HOLD;
  endfunction

  function automatic logic signed [CORR_W-1:0] apply_step(
      input logic signed [CORR_W-1:0] c, input step_e d);
    if (d == STEP_UP && c != CORR_MAX)   return c + ONE;
    if (d == STEP_DOWN && c != CORR_MIN) return c - ONE;
    return c;
  endfunction

  step_e step_dir;
  assign step_dir = pick_step(adc_sample, target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      corr_q <= '0;
    else if (clear)  corr_q <= '0;
    else if (enable) corr_q <= apply_step(corr_q, step_dir);
  end
endmodule

// File: rtl/osc_dac_sum.sv
`timescale 1ns/1ps
module osc_dac_sum #(
  parameter int CORR_W   = 8,
  parameter int CLAMP_W  = 7,
  parameter int DAC_W    = 10,
  parameter int CLAMP_LO = 14,
  parameter int CLAMP_HI = 76
) (
  input  logic signed [CORR_W-1:0] corr,
  input  logic [CLAMP_W-1:0]       clamp_raw,
  output logic [CLAMP_W-1:0]       clamp_eff,
  output logic [DAC_W-1:0]         dac_code
);
  localparam int BASE_W = (CORR_W > DAC_W) ? CORR_W : DAC_W;
  localparam int SUM_W  = ((BASE_W > CLAMP_W) ? BASE_W : CLAMP_W) + 2;
  localparam logic [CLAMP_W-1:0]     LO_V      = CLAMP_W'(CLAMP_LO);
  localparam logic [CLAMP_W-1:0]     HI_V      = CLAMP_W'(CLAMP_HI);
  localparam logic signed [SUM_W-1:0] DAC_MAX_S = SUM_W'((1 << DAC_W) - 1);

  function automatic logic [CLAMP_W-1:0] limit_clamp(input logic [CLAMP_W-1:0] r);
    if (r < LO_V) return LO_V;
    if (r > HI_V) return HI_V;
    return r;
  endfunction

  function automatic logic [DAC_W-1:0] sat_dac(input logic signed [SUM_W-1:0] s);
    if (s < 0)         return '0;
    if (s > DAC_MAX_S) return {DAC_W{1'b1}};
    return s[DAC_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] corr_x, clamp_x, sum;

  assign clamp_eff = limit_clamp(clamp_raw);
  assign corr_x    = {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};
  assign clamp_x   = {{(SUM_W-CLAMP_W){1'b0}}, clamp_eff};
  assign sum       = corr_x + clamp_x;
  assign dac_code  = sat_dac(sum);
endmodule

// File: rtl/osc_cal_seq.sv
`timescale 1ns/1ps
module osc_cal_seq
  import osc_pkg::*;
#(
  parameter int CAL_CYCLES = 40000,
  parameter int ADC_W      = 10,
  parameter int CORR_W     = 8,
  parameter int CLAMP_W    = 7,
  parameter int DAC_W      = 10,
  parameter int CLAMP_LO   = 14,
  parameter int CLAMP_HI   = 76
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_mode,
  input  logic [ADC_W-1:0]   adc_sample,
  input  logic [CLAMP_W-1:0] clamp_code,
  output logic [DAC_W-1:0]   dac_code,
  output logic               cal_busy,
  output logic               cal_done
);
  logic                     cal_start, cal_abort, cal_last;
  logic signed [CORR_W-1:0] corr_q;
  logic [CLAMP_W-1:0]       clamp_eff;
  logic [ADC_W-1:0]         target;

  assign target = ADC_W'(clamp_eff);

  osc_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_mode (rst_mode),
    .cal_busy (cal_busy),
    .cal_done (cal_done),
    .cal_start(cal_start),
    .cal_abort(cal_abort),
    .cal_last (cal_last)
  );

  osc_corr_accum #(.ADC_W(ADC_W), .CORR_W(CORR_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rst_mode),
    .enable    (cal_busy),
    .adc_sample(adc_sample),
    .target    (target),
    .corr_q    (corr_q)
  );

  osc_dac_sum #(
    .CORR_W(CORR_W), .CLAMP_W(CLAMP_W), .DAC_W(DAC_W),
    .CLAMP_LO(CLAMP_LO), .CLAMP_HI(CLAMP_HI)
  ) u_sum (
    .corr     (corr_q),
    .clamp_raw(clamp_code),
    .clamp_eff(clamp_eff),
    .dac_code (dac_code)
  );
endmodule

// File: rtl/osc_cal_seq_chk.sv
`timescale 1ns/1ps
module osc_cal_seq_chk #(
  parameter int CAL_CYCLES = 40000,
  parameter int CORR_W     = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rst_mode,
  input logic                     cal_busy,
  input logic                     cal_done,
  input logic                     cal_start,
  input logic                     cal_abort,
  input logic signed [CORR_W-1:0] corr_q
);
  localparam int LEN_W = $clog2(CAL_CYCLES + 2);
  localparam logic signed [CORR_W-1:0] ONE = CORR_W'(1);

  logic [LEN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (cal_busy) run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  // R2
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (run_len == LEN_W'(CAL_CYCLES)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> cal_busy);

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !rst_mode) |=> ((corr_q == $past(corr_q)) ||
                                 (corr_q == $past(corr_q) + ONE) ||
                                 (corr_q == $past(corr_q) - ONE)));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !rst_mode) |=> $stable(corr_q));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_mode |=> ((corr_q == '0) && !cal_busy && !cal_done));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_abort && cal_busy) |=> !cal_done);
endmodule

bind osc_cal_seq osc_cal_seq_chk #(
  .CAL_CYCLES(CAL_CYCLES), .CORR_W(CORR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_mode (rst_mode),
  .cal_busy (cal_busy),
  .cal_done (cal_done),
  .cal_start(cal_start),
  .cal_abort(cal_abort),
  .corr_q   (corr_q)
);

// File: tb/tb_osc_cal_seq.sv
`timescale 1ns/1ps
module tb_osc_cal_seq;
  localparam int WINDOW = 40000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_mode;
  logic [9:0] adc_sample;
  logic [6:0] clamp_code;
  logic [9:0] dac_code;
  logic       cal_busy, cal_done;

  int plant_off = 0;
  int n_cmp = 0;
  int n_bad = 0;

  osc_cal_seq dut (
    .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode), .adc_sample(adc_sample),
    .clamp_code(clamp_code), .dac_code(dac_code),
    .cal_busy(cal_busy), .cal_done(cal_done)
  );

  always #2 clk = ~clk;

  // Plant: converter sees the DAC code shifted by an analog offset
  always @(negedge clk) begin
    int v;
    v = int'(dac_code) + plant_off;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    adc_sample = 10'(v);
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int eff_clamp(input int c);
    if (c < 14) return 14;
    if (c > 76) return 76;
    return c;
  endfunction

  function automatic int exp_dac(input int c, input int corr);
    int s;
    s = eff_clamp(c) + corr;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  function automatic int settle(input int off);
    int c;
    c = -off;
    if (c > 127) c = 127;
    if (c < -128) c = -128;
    return c;
  endfunction

  // Full calibration run; called at a negedge
  task automatic run_cal(input int clamp, input int off, input string tag);
    int len, dones, guard;
    logic prev_busy;
    len = 0; dones = 0; guard = 0; prev_busy = 1'b0;
    clamp_code = 7'(clamp);
    plant_off  = off;
    rst_mode   = 1'b0;
    while (dones == 0 && guard < WINDOW + 100) begin
      @(negedge clk);
      guard++;
      if (cal_busy) len++;
      if (cal_done) begin
        dones++;
        chk({tag, " R3 done without busy"}, int'(cal_busy), 0);
        chk({tag, " R3 busy just fell"}, int'(prev_busy), 1);
      end
      prev_busy = cal_busy;
    end
    chk({tag, " R2 busy length"}, len, WINDOW);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, int'(cal_done), 0);
    chk({tag, " R4 R5 R6 settled dac"}, int'(dac_code), exp_dac(clamp, settle(off)));
  endtask

  // Post-calibration vectors: clamp code, plant disturbance, expected dac (corr = +20)
  localparam int VN = 5;
  localparam int V_CLAMP [VN] = '{14, 76, 0, 127, 50};
  localparam int V_OFF   [VN] = '{300, -300, 0, 5, -5};
  localparam int V_DAC   [VN] = '{34, 96, 34, 96, 70};

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int extra;
    rst_n = 1'b0; rst_mode = 1'b1; clamp_code = 7'd40; adc_sample = '0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", int'(cal_busy), 0);
    chk("R1 done in reset", int'(cal_done), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 armed busy", int'(cal_busy), 0);
    chk("R1 armed dac", int'(dac_code), 40);

    // Interior convergence: offset -20 -> correction +20
    run_cal(40, -20, "run1");

    // R8: no new window while rst_mode stays low
    extra = 0;
    repeat (50) begin
      @(negedge clk);
      if (cal_busy || cal_done) extra++;
    end
    chk("R8 no restart", extra, 0);

    // Table walk: clamp limiting and frozen correction under disturbance
    for (int i = 0; i < VN; i++) begin
      clamp_code = 7'(V_CLAMP[i]);
      plant_off  = V_OFF[i];
      @(negedge clk);
      chk($sformatf("R6 R7 vec%0d dac", i), int'(dac_code), V_DAC[i]);
      repeat (10) @(negedge clk);
      chk($sformatf("R8 vec%0d frozen", i), int'(dac_code), V_DAC[i]);
    end

    // R9: clear, restart, abort mid-window
    rst_mode = 1'b1;
    @(negedge clk);
    chk("R9 clear dac", int'(dac_code), 50);
    plant_off = -10;
    rst_mode = 1'b0;
    repeat (100) @(negedge clk);
    chk("R9 window running", int'(cal_busy), 1);
    rst_mode = 1'b1;
    @(negedge clk);
    chk("R9 abort busy", int'(cal_busy), 0);
    chk("R9 abort no done", int'(cal_done), 0);
    chk("R9 abort clears", int'(dac_code), 50);
    @(negedge clk);
    chk("R9 no late done", int'(cal_done), 0);

    // Negative stop: correction -128, dac floors at 0
    run_cal(14, 150, "run2");
    chk("R5 R6 floor dac", int'(dac_code), 0);

    // Positive stop: correction +127
    rst_mode = 1'b1;
    @(negedge clk);
    run_cal(76, -150, "run3");
    chk("R5 ceiling dac", int'(dac_code), 203);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule